// File: doc/BRIEF.md
# Bit-Serial Memory Port

This block is the memory end of a one-bit-wide processor bus. Three serial lines run to it, each with its own enable strobe. One line carries an address, one carries write data and one returns read data. Every transfer is one word of N bits, sent least significant bit first. A transfer finishes after N cycles in which its enable is high, and those cycles may be separated by idle cycles. The block holds a word-addressed RAM. The address it has shifted in selects the word that is read or written.

Each of the three channels keeps a bit position. A small state machine runs that position, with two states. `SEQ_IDLE` means no word is in progress and the position is zero. `SEQ_BUSY` means part of a word has moved. The *start* transition goes from `SEQ_IDLE` to `SEQ_BUSY` on the first enabled bit. The *finish* transition goes from `SEQ_BUSY` back to `SEQ_IDLE` on the N-th enabled bit. A read is answered in the same cycle it is requested, so the read-data line is driven without a register in its path. A write goes bit by bit into a staging register. The full word is stored on the clock edge of its last bit.

A parallel side port reads and writes the RAM directly. It is meant for preloading and inspecting memory while the serial strobes are idle. The block does not interpret the words it stores. The word width N must be at least 8.

Top module: `serial_mem_port`

## Requirements
- R1: Each enabled address cycle shifts the address register right by one and puts the new bit in its top position. After N enabled cycles the register holds the transmitted word, with the first bit as bit 0.
- R2: A channel's bit position advances only in cycles where that channel's enable is high. Idle cycles between enabled cycles leave the transfer unchanged.
- R3: While the read enable is high, `rd_bit` equals bit k of the word at the current address, where k is the read position, in that same cycle. While the read enable is low, `rd_bit` is 0.
- R4: A write stores the N collected bits at the current address on the clock edge of the N-th enabled write cycle. Before that edge the RAM word keeps its old value.
- R5: Each bit position returns to zero after its N-th enabled bit, so transfers can follow one another back to back.
- R6: `strobe_clash` is 1 in exactly those cycles where two or more of the three enables are high.
- R7: Only the low `AW` address bits select a RAM word. Address bits above them have no effect on which word is read or written.
- R8: A synchronous reset clears all three bit positions, the address register and the staging register. It does not change the RAM contents and blocks a serial write commit in that cycle.
- R9: `side_rdata` shows the word at `side_addr` without a clock edge. `side_we` writes `side_wdata` there on the clock edge. A serial commit in the same cycle takes precedence, and the side write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adr_bit | input | 1 | Serial address bit |
| adr_en | input | 1 | Address bit is valid this cycle |
| wr_bit | input | 1 | Serial write-data bit |
| wr_en | input | 1 | Write bit is valid this cycle |
| rd_en | input | 1 | Read bit requested this cycle |
| rd_bit | output | 1 | Serial read-data bit, valid in the cycle of the request |
| strobe_clash | output | 1 | More than one enable is high |
| side_addr | input | AW | Parallel RAM address |
| side_we | input | 1 | Parallel write strobe |
| side_wdata | input | N | Parallel write word |
| side_rdata | output | N | Parallel read word |

## Verification
Before any address is sent, a read right after reset shows whether the address register really starts at zero. Words are then loaded and read with contiguous strobes and with strobes spaced by idle gaps. When the gapped transfers return the same words as the contiguous ones, the position counters are advancing only on enabled cycles. An address with its high bits set checks that those bits are ignored. During a write, the RAM word is sampled just before and just after the last bit, which pins the commit to the correct edge. A deliberate enable collision and a reset in the middle of a transfer exercise the error flag, and show that reset clears the channel state while leaving memory alone.

// File: rtl/smem_pkg.sv
package smem_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

    localparam int unsigned CH_ADR = 0;
    localparam int unsigned CH_WR  = 1;
    localparam int unsigned CH_RD  = 2;
    localparam int unsigned NUM_CH = 3;
endpackage

// File: rtl/smem_bit_seq.sv
module smem_bit_seq
    import smem_pkg::*;
#(
    parameter int unsigned N  = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [IW-1:0] idx,
    output logic          last
);
    seq_state_t    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          at_top;

    assign at_top = (idx_q == IW'(N - 1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // next state: start on first enabled bit, finish on the N-th
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (step)           state_d = SEQ_BUSY;
            SEQ_BUSY: if (step && at_top) state_d = SEQ_IDLE;
            default:                      state_d = SEQ_IDLE;
        endcase
    end

    // bit position
    always_ff @(posedge clk) begin
        if (rst)       idx_q <= '0;
        else if (step) idx_q <= at_top ? '0 : idx_q + IW'(1);
    end

    // outputs
    always_comb begin
        idx  = idx_q;
        last = step && at_top;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx_q));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (step && idx_q != IW'(N - 1)) |=> (idx_q == $past(idx_q) + IW'(1)));
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && idx_q == IW'(N - 1)) |=> (idx_q == '0));
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> (idx_q == '0));
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (idx_q == '0 && state_q == SEQ_IDLE));
endmodule

// File: rtl/smem_shift_in.sv
module smem_shift_in #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {din, q[N-1:1]};
    end
endmodule

// File: rtl/smem_ram.sv
module smem_ram #(
    parameter int unsigned N  = 16,
    parameter int unsigned AW = 12,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_we,
    input  logic [AW-1:0] ser_addr,
    input  logic [N-1:0]  ser_wdata,
    output logic [N-1:0]  ser_rdata,
    input  logic          side_we,
    input  logic [AW-1:0] side_addr,
    input  logic [N-1:0]  side_wdata,
    output logic [N-1:0]  side_rdata
);
    logic [N-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ser_we)       mem[ser_addr]  <= ser_wdata;
        else if (side_we) mem[side_addr] <= side_wdata;
    end

    assign ser_rdata  = mem[ser_addr];
    assign side_rdata = mem[side_addr];

    p_commit_r4: assert property (@(posedge clk) disable iff (rst)
        ser_we |=> (mem[$past(ser_addr)] == $past(ser_wdata)));
    p_side_r9: assert property (@(posedge clk) disable iff (rst)
        (side_we && !ser_we) |=> (mem[$past(side_addr)] == $past(side_wdata)));
endmodule

// File: rtl/serial_mem_port.sv
module serial_mem_port
    import smem_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned AW = 12,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adr_bit,
    input  logic          adr_en,
    input  logic          wr_bit,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          rd_bit,
    output logic          strobe_clash,
    input  logic [AW-1:0] side_addr,
    input  logic          side_we,
    input  logic [N-1:0]  side_wdata,
    output logic [N-1:0]  side_rdata
);
    logic [NUM_CH-1:0] ch_step;
    logic [NUM_CH-1:0] ch_last;
    logic [IW-1:0]     ch_idx [NUM_CH];
    logic [N-1:0]      addr_q, stage_q, row;
    logic              commit;

    assign ch_step[CH_ADR] = adr_en;
    assign ch_step[CH_WR]  = wr_en;
    assign ch_step[CH_RD]  = rd_en;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_seq
        smem_bit_seq #(.N(N)) u_seq (
            .clk  (clk),
            .rst  (rst),
            .step (ch_step[g]),
            .idx  (ch_idx[g]),
            .last (ch_last[g])
        );
    end

    smem_shift_in #(.N(N)) u_addr (
        .clk (clk), .rst (rst), .en (adr_en), .din (adr_bit), .q (addr_q)
    );

    smem_shift_in #(.N(N)) u_stage (
        .clk (clk), .rst (rst), .en (wr_en), .din (wr_bit), .q (stage_q)
    );

    assign commit = ch_last[CH_WR] && !rst;

    smem_ram #(.N(N), .AW(AW)) u_ram (
        .clk        (clk),
        .rst        (rst),
        .ser_we     (commit),
        .ser_addr   (addr_q[AW-1:0]),
        .ser_wdata  ({wr_bit, stage_q[N-1:1]}),
        .ser_rdata  (row),
        .side_we    (side_we),
        .side_addr  (side_addr),
        .side_wdata (side_wdata),
        .side_rdata (side_rdata)
    );

    // unused upper address bits and stage bit 0 are shifted out by design
    logic unused_ok;
    assign unused_ok = ^{addr_q, stage_q[0], ch_last[CH_ADR], ch_last[CH_RD], ch_idx[CH_ADR], ch_idx[CH_WR]};

    always_comb begin
        rd_bit       = rd_en & row[ch_idx[CH_RD]];
        strobe_clash = (adr_en & wr_en) | (adr_en & rd_en) | (wr_en & rd_en);
    end

    p_clash_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe_clash |-> $onehot0(ch_step));
    p_rd_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> !rd_bit);
    p_addr_top_r1: assert property (@(posedge clk) disable iff (rst)
        adr_en |=> (addr_q[N-1] == $past(adr_bit)));
endmodule

// File: tb/sim_serial_mem_port.sv
module sim_serial_mem_port;
    localparam int N  = 16;
    localparam int AW = 12;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adr_bit = 0, adr_en = 0, wr_bit = 0, wr_en = 0, rd_en = 0;
    logic rd_bit, strobe_clash;
    logic [AW-1:0] side_addr = '0;
    logic side_we = 0;
    logic [N-1:0] side_wdata = '0;
    logic [N-1:0] side_rdata;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // behavioural reference state
    logic [N-1:0] m_mem [DEPTH];
    logic [N-1:0] m_addr = '0, m_stage = '0;
    int m_aidx = 0, m_widx = 0, m_ridx = 0;

    always #4 clk = ~clk;

    serial_mem_port #(.N(N), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .adr_bit(adr_bit), .adr_en(adr_en),
        .wr_bit(wr_bit), .wr_en(wr_en), .rd_en(rd_en), .rd_bit(rd_bit),
        .strobe_clash(strobe_clash), .side_addr(side_addr), .side_we(side_we),
        .side_wdata(side_wdata), .side_rdata(side_rdata)
    );

    function automatic logic [N-1:0] pat(int i);
        return N'(i * 40503) ^ 16'h03C1;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare outputs, advance one clock, update the model
    task automatic tick(output logic rb);
        logic [N-1:0] row;
        logic exp_rd;
        logic [N-1:0] nxt;
        #1;
        rb = rd_bit;
        row = m_mem[m_addr[AW-1:0]];
        exp_rd = rd_en ? row[m_ridx] : 1'b0;
        if (!rst) begin
            chk("R3 rd_bit vs model", {15'b0, rd_bit}, {15'b0, exp_rd});
            chk("R6 strobe_clash vs model", {15'b0, strobe_clash},
                {15'b0, ((adr_en + wr_en + rd_en) > 1) ? 1'b1 : 1'b0});
            if (m_mem[side_addr] !== 'x)
                chk("R9 side_rdata vs model", side_rdata, m_mem[side_addr]);
        end
        @(posedge clk);
        if (rst) begin
            if (side_we) m_mem[side_addr] = side_wdata;
            m_addr = '0; m_stage = '0; m_aidx = 0; m_widx = 0; m_ridx = 0;
        end else begin
            nxt = {wr_bit, m_stage[N-1:1]};
            if (wr_en && m_widx == N - 1) m_mem[m_addr[AW-1:0]] = nxt;
            else if (side_we) m_mem[side_addr] = side_wdata;
            if (wr_en) begin m_stage = nxt; m_widx = (m_widx + 1) % N; end
            if (adr_en) begin m_addr = {adr_bit, m_addr[N-1:1]}; m_aidx = (m_aidx + 1) % N; end
            if (rd_en) m_ridx = (m_ridx + 1) % N;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        logic d;
        adr_en = 0; wr_en = 0; rd_en = 0; side_we = 0;
        for (int k = 0; k < n; k++) tick(d);
    endtask

    task automatic send_addr(logic [N-1:0] v, int gap);
        logic d;
        for (int k = 0; k < N; k++) begin
            adr_en = 1; adr_bit = v[k]; tick(d);
            adr_en = 0; for (int j = 0; j < gap; j++) tick(d);
        end
    endtask

    task automatic get_word(output logic [N-1:0] w, input int gap);
        logic b;
        for (int k = 0; k < N; k++) begin
            rd_en = 1; tick(b); w[k] = b;
            rd_en = 0; for (int j = 0; j < gap; j++) tick(b);
        end
    endtask

    task automatic send_bits(logic [N-1:0] v, int from, int upto, int gap);
        logic d;
        for (int k = from; k < upto; k++) begin
            wr_en = 1; wr_bit = v[k]; tick(d);
            wr_en = 0; for (int j = 0; j < gap; j++) tick(d);
        end
    endtask

    initial begin
        logic [N-1:0] w;
        logic d;
        @(negedge clk);
        // preload every word through the side port while in reset
        for (int a = 0; a < DEPTH; a++) begin
            side_addr = AW'(a); side_we = 1; side_wdata = pat(a); tick(d);
        end
        side_we = 0; side_addr = AW'(5);
        rst = 0;
        chk("R6 clash low at rest", {15'b0, strobe_clash}, 16'h0);
        chk("R3 rd_bit low at rest", {15'b0, rd_bit}, 16'h0);

        // R8: address starts at zero, so a read returns word 0
        get_word(w, 0);
        chk("R8 read after reset hits word 0", w, pat(0));
        // R1/R3 contiguous load and read
        send_addr(16'h0005, 0);
        get_word(w, 0);
        chk("R1 contiguous address load, word 5", w, pat(5));
        // R5 back to back reread
        get_word(w, 0);
        chk("R5 back-to-back second read", w, pat(5));
        // R2 gapped transfers
        send_addr(16'h0ABC, 2);
        get_word(w, 3);
        chk("R2 gapped load and read, word ABC", w, pat(12'hABC));
        // R7 high bits ignored
        send_addr(16'hFABC, 1);
        get_word(w, 0);
        chk("R7 high address bits ignored", w, pat(12'hABC));
        // R4 write to word 5 with gaps
        send_addr(16'h0005, 0);
        send_bits(16'h5A0F, 0, N - 1, 1);
        chk("R4 word unchanged before last bit", side_rdata, pat(5));
        send_bits(16'h5A0F, N - 1, N, 0);
        chk("R4 word stored on last bit edge", side_rdata, 16'h5A0F);
        get_word(w, 0);
        chk("R4 serial read of stored word", w, 16'h5A0F);
        // R9 side write and combinational read
        side_addr = AW'(9); side_wdata = 16'hC0DE; side_we = 1; tick(d);
        side_we = 0;
        chk("R9 side write visible", side_rdata, 16'hC0DE);
        // R6 collision
        adr_en = 1; rd_en = 1; adr_bit = 1; #1;
        chk("R6 clash with address and read", {15'b0, strobe_clash}, 16'h1);
        tick(d);
        adr_en = 0; wr_en = 1; rd_en = 1; #1;
        chk("R6 clash with write and read", {15'b0, strobe_clash}, 16'h1);
        tick(d);
        idle(1);
        // R8 reset mid-transfer keeps RAM
        send_addr(16'h0003, 0);
        rst = 1; idle(2); rst = 0;
        side_addr = AW'(5);
        chk("R8 RAM preserved across reset", side_rdata, 16'h5A0F);
        get_word(w, 0);
        chk("R8 positions and address cleared", w, pat(0));
        send_addr(16'h0009, 0);
        get_word(w, 1);
        chk("R9 side-written word read serially", w, 16'hC0DE);
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule